// File: doc/BRIEF.md
# PWM Event Action Qualifier

This block turns counter events into two PWM output levels, A and B. A separate time-base counter supplies a counting tick and, in the same cycle, strobes that say the counter sits at zero, at the period value, at compare A while counting up, or at compare B while counting up. For each output, a programmable action word assigns one of four actions to each event. Each action is 2 bits wide and means leave the level, drive low, drive high or toggle. When several events land on the same tick, a fixed priority picks the one that acts.

A software force register sits above the event actions and can hold either output low or high for as long as software wants. Writes go to a shadow copy. A reload mode, also held in that register, decides when the shadow copy becomes the active force: at counter zero, at counter period, at either of them, or straight away. Software produces normal polarity by driving high at zero and at period and low at the compare match. It produces inverted polarity by reversing those three levels.

Top module: `pwm_action_qualifier`

## Requirements
- R1: While reset is asserted, and after it is released, both outputs are low, both action words are zero and the force shadow, active force and reload mode are all zero. After reset with no writes, events leave the outputs low.
- R2: Action codes are 0 = no change, 1 = drive low, 2 = drive high and 3 = toggle. The new level shows on the output at the clock edge that samples the tick.
- R3: In both action words, the zero action sits at bits 1:0 and the period action at bits 3:2. Output A's compare-A-up action sits at bits 5:4 of its word. Output B's compare-B-up action sits at bits 9:8 of its word. Register select 0 writes A's action word, select 1 writes B's action word and select 2 writes the force register.
- R4: Among the events present in a tick, the compare event has highest priority, then period, then zero. The highest-priority event that is present alone decides the action, even when its code is 0.
- R5: An output changes only on a cycle with the tick high. Event strobes without a tick have no effect.
- R6: Force field bits 1:0 control A and bits 3:2 control B. Code 1 holds the output low and code 2 holds it high, whatever events arrive. Codes 0 and 3 hand control back to the event actions.
- R7: The reload mode sits at bits 7:6 of the force register. Mode 0 copies the shadow force to the active force on a tick with counter zero. Mode 1 does so on a tick with counter period. Mode 2 does so on a tick with either. That copy applies to the same tick.
- R8: In reload mode 3 a written force reaches the output at the first tick after the write, and not before.
- R9: A write with register select 3 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counting tick; events are used only with it |
| ev_zero | input | 1 | Counter equals zero |
| ev_period | input | 1 | Counter equals period |
| ev_cmpa_up | input | 1 | Counter equals compare A while counting up |
| ev_cmpb_up | input | 1 | Counter equals compare B while counting up |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 action A, 1 action B, 2 force, 3 none) |
| wr_data | input | WORD_W | Write data |
| pwm_a | output | 1 | Output A level |
| pwm_b | output | 1 | Output B level |

## Verification
The bench builds the block with the default WORD_W of 16. At that width every action field is reachable, including the compare-B field at bits 9:8. An all-ones write through the unused select then sets every bit that a misrouted write could corrupt, so such a write would show as a wrong output level. With normal polarity on A and inverted polarity on B, a table of combined event patterns checks the priority between simultaneous events on both outputs at once. Directed sequences then step through each reload mode, placing the loading event one tick apart from an event that must not load.

// File: rtl/pwm_action_qualifier.sv
module pwm_action_qualifier #(
  parameter int WORD_W = 16  // must be at least 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ev_zero,
  input  logic              ev_period,
  input  logic              ev_cmpa_up,
  input  logic              ev_cmpb_up,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  output logic              pwm_a,
  output logic              pwm_b
);

  localparam logic [1:0] SEL_ACT_A = 2'd0;
  localparam logic [1:0] SEL_ACT_B = 2'd1;
  localparam logic [1:0] SEL_FORCE = 2'd2;
  localparam logic [1:0] CODE_LOW  = 2'd1;
  localparam logic [1:0] CODE_HIGH = 2'd2;

  logic [5:0] act_a;
  logic [9:0] act_b;
  logic [3:0] frc_shadow, frc_active, frc_eff;
  logic [1:0] reload_mode;
  logic       load_now;
  logic       nxt_a, nxt_b;

  function automatic logic resolve(input logic cur, input logic [1:0] frc,
                                   input logic [1:0] a_zero, input logic [1:0] a_prd,
                                   input logic [1:0] a_cmp, input logic z,
                                   input logic p, input logic c);
    logic [1:0] act;
    logic       lvl;
    act = c ? a_cmp : (p ? a_prd : (z ? a_zero : 2'd0));
    case (act)
      2'd1:    lvl = 1'b0;
      2'd2:    lvl = 1'b1;
      2'd3:    lvl = ~cur;
      default: lvl = cur;
    endcase
    if (frc == CODE_LOW)       lvl = 1'b0;
    else if (frc == CODE_HIGH) lvl = 1'b1;
    return lvl;
  endfunction

  always_comb begin
    case (reload_mode)
      2'd0:    load_now = tick & ev_zero;
      2'd1:    load_now = tick & ev_period;
      2'd2:    load_now = tick & (ev_zero | ev_period);
      default: load_now = 1'b1;
    endcase
  end

  assign frc_eff = load_now ? frc_shadow : frc_active;
  assign nxt_a = resolve(pwm_a, frc_eff[1:0], act_a[1:0], act_a[3:2], act_a[5:4],
                         ev_zero, ev_period, ev_cmpa_up);
  assign nxt_b = resolve(pwm_b, frc_eff[3:2], act_b[1:0], act_b[3:2], act_b[9:8],
                         ev_zero, ev_period, ev_cmpb_up);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_a       <= '0;
      act_b       <= '0;
      frc_shadow  <= '0;
      reload_mode <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_ACT_A: act_a <= wr_data[5:0];
        SEL_ACT_B: act_b <= wr_data[9:0];
        SEL_FORCE: begin
          frc_shadow  <= wr_data[3:0];
          reload_mode <= wr_data[7:6];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frc_active <= '0;
      pwm_a      <= 1'b0;
      pwm_b      <= 1'b0;
    end else begin
      frc_active <= frc_eff;
      if (tick) begin
        pwm_a <= nxt_a;
        pwm_b <= nxt_b;
      end
    end
  end

  assert_hold_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(pwm_a) && $stable(pwm_b)));

  assert_force_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && frc_eff[1:0] == CODE_LOW) |=> !pwm_a);

  assert_force_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && frc_eff[3:2] == CODE_HIGH) |=> pwm_b);

  assert_active_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_now |=> $stable(frc_active));

  assert_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ev_zero && !ev_period && !ev_cmpa_up && act_a[1:0] == 2'd3 &&
     (frc_eff[1:0] == 2'd0 || frc_eff[1:0] == 2'd3)) |=> (pwm_a != $past(pwm_a)));

endmodule

// File: tb/pwm_action_qualifier_tb.sv
module pwm_action_qualifier_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, ev_zero = 1'b0, ev_period = 1'b0, ev_cmpa_up = 1'b0, ev_cmpb_up = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic pwm_a, pwm_b;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pwm_action_qualifier #(.WORD_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ev_zero(ev_zero), .ev_period(ev_period),
    .ev_cmpa_up(ev_cmpa_up), .ev_cmpb_up(ev_cmpb_up), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b));

  // {zero, period, cmpa, cmpb, exp_a, exp_b}; A normal polarity, B inverted
  localparam logic [5:0] VEC [8] = '{
    6'b1000_10, 6'b0010_00, 6'b0001_01, 6'b0100_10,
    6'b0000_10, 6'b0110_00, 6'b1001_11, 6'b1111_01};

  task automatic check(input logic ea, input logic eb, input string req);
    checks++;
    if (pwm_a !== ea || pwm_b !== eb) begin
      errors++;
      $display("FAIL %s: pwm_a=%0b pwm_b=%0b expected %0b %0b", req, pwm_a, pwm_b, ea, eb);
    end
  endtask

  task automatic step(input logic t, input logic z, input logic p, input logic ca, input logic cb);
    tick = t; ev_zero = z; ev_period = p; ev_cmpa_up = ca; ev_cmpb_up = cb;
    @(negedge clk);
    tick = 0; ev_zero = 0; ev_period = 0; ev_cmpa_up = 0; ev_cmpb_up = 0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_sel = 0; wr_data = 0;
  endtask

  initial begin
    #200000ns;
    errors++; checks++;
    $display("FAIL watchdog: pwm_a=%0b pwm_b=%0b expected run to finish", pwm_a, pwm_b);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check(0, 0, "R1 in reset");
    rst_n = 1;
    @(negedge clk);
    step(1, 1, 1, 1, 1);
    check(0, 0, "R1 cleared actions after reset");

    wr(2'd0, 16'h001A);   // R3: A zero high, period high, cmpA low
    wr(2'd1, 16'h0205);   // R3: B zero low, period low, cmpB high
    foreach (VEC[i]) begin
      step(1, VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      check(VEC[i][1], VEC[i][0], "R2 R3 R4 event table");
    end

    step(0, 1, 1, 1, 1);
    check(0, 1, "R5 events without tick");

    wr(2'd2, 16'h00C6);   // mode 3, A high, B low
    step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    check(0, 1, "R8 no change before tick");
    step(1, 0, 0, 1, 1);
    check(1, 0, "R8 R6 forced at tick over events");

    wr(2'd2, 16'h0001);   // mode 0, A low
    step(1, 0, 1, 0, 0);
    check(1, 0, "R7 mode0 period does not load");
    step(1, 1, 0, 0, 0);
    check(0, 0, "R7 mode0 zero loads");
    step(1, 0, 0, 0, 1);
    check(0, 1, "R6 B released A held low");

    wr(2'd2, 16'h0042);   // mode 1, A high
    step(1, 1, 0, 0, 0);
    check(0, 0, "R7 mode1 zero does not load");
    step(1, 0, 1, 0, 0);
    check(1, 0, "R7 mode1 period loads");

    wr(2'd2, 16'h0081);   // mode 2, A low
    step(1, 0, 0, 0, 0);
    check(1, 0, "R7 mode2 plain tick does not load");
    step(1, 1, 0, 0, 0);
    check(0, 0, "R7 mode2 zero loads");
    wr(2'd2, 16'h0082);
    step(1, 0, 1, 0, 0);
    check(1, 0, "R7 mode2 period loads");

    wr(2'd2, 16'h00C3);   // mode 3, A code 3 = released
    step(1, 0, 0, 1, 0);
    check(0, 0, "R6 code 3 releases force");

    wr(2'd0, 16'h0003);   // A: zero toggles only
    step(1, 1, 0, 0, 0);
    check(1, 0, "R2 toggle up");
    step(1, 1, 0, 0, 0);
    check(0, 0, "R2 toggle down");
    step(1, 1, 1, 0, 0);
    check(0, 0, "R4 period with no action masks zero");
    step(1, 1, 0, 1, 0);
    check(0, 0, "R4 compare with no action masks zero");

    wr(2'd3, 16'hFFFF);
    step(1, 1, 0, 0, 0);
    check(1, 0, "R9 select 3 ignored");
    step(1, 1, 1, 0, 0);
    check(1, 0, "R9 select 3 left period actions");

    rst_n = 0;
    @(negedge clk);
    check(0, 0, "R1 reset mid run");
    rst_n = 1;
    @(negedge clk);
    step(1, 1, 0, 0, 0);
    check(0, 0, "R1 actions cleared by reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule